// File: doc/BRIEF.md
# Programmable Pixel Sync Edge Detector

This block produces the per-pixel timing strobes that drive sampling in an image sensor front end. It runs entirely on the master clock. The external sync pin is first brought into the master-clock domain through a two-flop synchroniser. In pass-through mode the synchronised level becomes the internal sync pulse with no change in shape. In detect mode the block watches the sync pin for a chosen edge of any periodic waveform. It waits a programmable number of master clocks after that edge and then issues a one-clock internal sync pulse.

Two sampling strobes are derived from the internal pulse. The video strobe marks the cycle right after the pulse ends. The reset strobe marks the reset-level sample, and its position can be moved by up to two clocks. A clamp strobe accompanies the reset strobe when the clamp request bit was high during the sync pulse. That choice is made pixel by pixel. A separate half-ratio mode bit pins the reset strobe to its normal position, which is the placement that operation at two master clocks per pixel needs.

Top module: `pxsync_top`

## Requirements
- R1: With `detectEn` low, `syncPulse` reproduces the level on `syncIn` delayed by three rising clock edges, with its width unchanged. The edge used by the synchroniser is counted as edge 1. `edgeRising` and `delaySel` have no effect in this mode.
- R2: With `detectEn` high, `edgeRising`=1 selects a 0-to-1 transition of `syncIn` and `edgeRising`=0 selects a 1-to-0 transition. The opposite transition produces no pulse.
- R3: In detect mode, `syncPulse` is high for exactly one clock, starting on rising edge 3+`delaySel`, where edge 1 is the first edge that samples the new level of `syncIn`.
- R4: If a selected edge arrives while a delayed pulse is still pending, the pending pulse is dropped. Only one pulse is issued, timed from the newer edge.
- R5: `videoStrobe` is high for exactly the one clock cycle that follows the last high cycle of `syncPulse`.
- R6: `resetStrobe` is one clock long. It rises 1, 2, 3 or 4 cycles after `videoStrobe` for `resetPos` = 00, 01, 10 or 11 respectively, with the default base offset of 2.
- R7: `clampReq` is sampled on the clock edge that closes each high cycle of `syncPulse`. `clampStrobe` accompanies that pixel's `resetStrobe` exactly when the last sampled value was 1, and stays low otherwise.
- R8: With `ratio2Mode` high, `resetPos` is ignored and the reset strobe takes the 01 position.
- R9: During reset and after reset with the sync pin idle, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Raw external sync pin |
| detectEn | input | 1 | 1 selects edge detect mode, 0 selects pass-through |
| edgeRising | input | 1 | Edge selection in detect mode: 1 rising, 0 falling |
| delaySel | input | DELAY_W (3) | Master clocks of delay after the detected edge |
| resetPos | input | 2 | Reset/clamp strobe position, 00 earliest to 11 latest |
| ratio2Mode | input | 1 | Half-ratio mode; forces the normal reset position |
| clampReq | input | 1 | Per-pixel clamp enable, sampled during the sync pulse |
| syncPulse | output | 1 | Internal sync pulse |
| videoStrobe | output | 1 | Video sample strobe |
| resetStrobe | output | 1 | Reset-level sample strobe |
| clampStrobe | output | 1 | Clamp strobe |

## Verification
The clamp decision for one pixel and the reset strobe of the previous pixel fall in the same window. With the earliest reset position, the reset strobe of a pixel comes one cycle after its video strobe. The clamp sample for the next pixel can then be taken in the same cycle that the reset strobe of the current pixel is emitted. The bench sweeps every combination of polarity, delay, reset position and clamp bit, and it predicts the pulse, video, reset and clamp cycles arithmetically from the edge time. A restart case sends a second edge while a long delay is still counting. The bench judges pass or fail on whether exactly one pulse appears, at the later-derived cycle.

// File: rtl/pxsync_pkg.sv
package pxsync_pkg;

  // Strobes handed from the control half to the datapath half.
  typedef struct packed {
    logic pulse;        // internal sync pulse, one clock in detect mode
    logic video;        // cycle right after the pulse ends
    logic clampSample;  // capture enable for the clamp request bit
  } pxStrobes_t;

  localparam int unsigned POS_COUNT = 4;  // reset-strobe positions 00..11
  localparam logic [1:0]  POS_NORMAL = 2'b01;

endpackage

// File: rtl/pxsync_sync.sv
module pxsync_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/pxsync_ctrl.sv
module pxsync_ctrl
  import pxsync_pkg::*;
#(
  parameter int unsigned DELAY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               syncLvl,
  input  logic               detectEn,
  input  logic               edgeRising,
  input  logic [DELAY_W-1:0] delaySel,
  output pxStrobes_t         strobes
);

  logic               syncPrev;
  logic               pending;
  logic [DELAY_W-1:0] countQ;
  logic               pulseQ;
  logic               pulseDly;
  logic               riseSeen;
  logic               fallSeen;
  logic               edgeSeen;
  logic               zeroDelay;

  assign riseSeen  = syncLvl & ~syncPrev;
  assign fallSeen  = ~syncLvl & syncPrev;
  assign edgeSeen  = detectEn & (edgeRising ? riseSeen : fallSeen);
  assign zeroDelay = (delaySel == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncPrev <= 1'b0;
      pending  <= 1'b0;
      countQ   <= '0;
      pulseQ   <= 1'b0;
      pulseDly <= 1'b0;
    end else begin
      syncPrev <= syncLvl;
      pulseDly <= pulseQ;
      if (!detectEn) begin
        // pass-through: synchronised level drives the pulse register
        pulseQ  <= syncLvl;
        pending <= 1'b0;
        countQ  <= '0;
      end else if (edgeSeen) begin
        // a fresh edge always restarts the delay, dropping any pending pulse
        if (zeroDelay) begin
          pulseQ  <= 1'b1;
          pending <= 1'b0;
        end else begin
          pulseQ  <= 1'b0;
          pending <= 1'b1;
          countQ  <= delaySel;
        end
      end else if (pending) begin
        countQ <= countQ - 1'b1;
        if (countQ == DELAY_W'(1)) begin
          pulseQ  <= 1'b1;
          pending <= 1'b0;
        end else begin
          pulseQ <= 1'b0;
        end
      end else begin
        pulseQ <= 1'b0;
      end
    end
  end

  assign strobes.pulse       = pulseQ;
  assign strobes.video       = pulseDly & ~pulseQ;
  assign strobes.clampSample = pulseQ;

endmodule

// File: rtl/pxsync_path.sv
module pxsync_path
  import pxsync_pkg::*;
#(
  parameter int unsigned RESET_BASE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pxStrobes_t strobes,
  input  logic [1:0] resetPos,
  input  logic       ratio2Mode,
  input  logic       clampReq,
  output logic       resetStrobe,
  output logic       clampStrobe
);

  // Pipe stage j is high j+1 cycles after the video strobe.
  localparam int unsigned PIPE_DEPTH = RESET_BASE + POS_COUNT - 2;

  logic                  clampHeld;
  logic [PIPE_DEPTH-1:0] rstPipe;
  logic [PIPE_DEPTH-1:0] clampPipe;
  logic [POS_COUNT-1:0]  rstTaps;
  logic [POS_COUNT-1:0]  clampTaps;
  logic [1:0]            posEff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clampHeld <= 1'b0;
      rstPipe   <= '0;
      clampPipe <= '0;
    end else begin
      if (strobes.clampSample) clampHeld <= clampReq;
      rstPipe   <= {rstPipe[PIPE_DEPTH-2:0], strobes.video};
      clampPipe <= {clampPipe[PIPE_DEPTH-2:0], strobes.video & clampHeld};
    end
  end

  for (genvar p = 0; p < POS_COUNT; p++) begin : g_tap
    assign rstTaps[p]   = rstPipe[RESET_BASE + p - 2];
    assign clampTaps[p] = clampPipe[RESET_BASE + p - 2];
  end

  assign posEff      = ratio2Mode ? POS_NORMAL : resetPos;
  assign resetStrobe = rstTaps[posEff];
  assign clampStrobe = clampTaps[posEff];

endmodule

// File: rtl/pxsync_top.sv
module pxsync_top
  import pxsync_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DELAY_W     = 3,
  parameter int unsigned RESET_BASE  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               syncIn,
  input  logic               detectEn,
  input  logic               edgeRising,
  input  logic [DELAY_W-1:0] delaySel,
  input  logic [1:0]         resetPos,
  input  logic               ratio2Mode,
  input  logic               clampReq,
  output logic               syncPulse,
  output logic               videoStrobe,
  output logic               resetStrobe,
  output logic               clampStrobe
);

  logic       syncLvl;
  pxStrobes_t strobes;

  pxsync_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn (syncIn),
    .syncOut (syncLvl)
  );

  pxsync_ctrl #(.DELAY_W(DELAY_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .syncLvl    (syncLvl),
    .detectEn   (detectEn),
    .edgeRising (edgeRising),
    .delaySel   (delaySel),
    .strobes    (strobes)
  );

  pxsync_path #(.RESET_BASE(RESET_BASE)) i_path (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .resetPos    (resetPos),
    .ratio2Mode  (ratio2Mode),
    .clampReq    (clampReq),
    .resetStrobe (resetStrobe),
    .clampStrobe (clampStrobe)
  );

  assign syncPulse   = strobes.pulse;
  assign videoStrobe = strobes.video;

endmodule

// File: rtl/pxsync_checker.sv
module pxsync_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       detectEn,
  input logic [1:0] resetPos,
  input logic       ratio2Mode,
  input logic       syncPulse,
  input logic       videoStrobe,
  input logic       resetStrobe,
  input logic       clampStrobe
);

  // R3: in steady detect mode the internal pulse never lasts two clocks
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (detectEn && $past(detectEn) && syncPulse) |=> (!syncPulse || !detectEn));

  // R5: the end of every sync pulse is followed by a video strobe
  p_video_after_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(syncPulse) |-> videoStrobe);

  // R5: video strobe lasts one clock
  p_video_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    videoStrobe |=> !videoStrobe);

  // R7: clamp only alongside a reset strobe
  p_clamp_in_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clampStrobe |-> resetStrobe);

  // R6: reset strobe lasts one clock while its position setting is held
  p_reset_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resetStrobe |=> (!resetStrobe || !$stable(resetPos) || !$stable(ratio2Mode)));

endmodule

bind pxsync_top pxsync_checker i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .detectEn    (detectEn),
  .resetPos    (resetPos),
  .ratio2Mode  (ratio2Mode),
  .syncPulse   (syncPulse),
  .videoStrobe (videoStrobe),
  .resetStrobe (resetStrobe),
  .clampStrobe (clampStrobe)
);

// File: tb/test_pxsync_top.sv
module test_pxsync_top;

  localparam int RB = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       syncIn;
  logic       detectEn;
  logic       edgeRising;
  logic [2:0] delaySel;
  logic [1:0] resetPos;
  logic       ratio2Mode;
  logic       clampReq;
  logic       syncPulse;
  logic       videoStrobe;
  logic       resetStrobe;
  logic       clampStrobe;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pxsync_top i_pxsync_top (
    .clk(clk), .rst_n(rst_n), .syncIn(syncIn), .detectEn(detectEn),
    .edgeRising(edgeRising), .delaySel(delaySel), .resetPos(resetPos),
    .ratio2Mode(ratio2Mode), .clampReq(clampReq), .syncPulse(syncPulse),
    .videoStrobe(videoStrobe), .resetStrobe(resetStrobe), .clampStrobe(clampStrobe)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0b expected %0b", tag, what, $time, act, exp);
    end
  endtask

  // Compare all outputs at sample i for a pulse window [ps,pe].
  task automatic checkAll(input int i, input int ps, input int pe, input int posEff,
                          input logic clampBit, input string pulseTag, input string resetTag);
    int rIdx = pe + RB + posEff;
    check(pulseTag, "syncPulse", syncPulse, (i >= ps && i <= pe));
    check("R5", "videoStrobe", videoStrobe, (i == pe + 1));
    check(resetTag, "resetStrobe", resetStrobe, (i == rIdx));
    check("R7", "clampStrobe", clampStrobe, (i == rIdx) && clampBit);
  endtask

  // One pixel: configure, idle, then present one active phase.
  task automatic runCase(input logic det, input logic pol, input int dly, input int pos,
                         input logic r2, input logic clampBit, input int width,
                         input string pulseTag, input string resetTag);
    logic idle = det ? ~pol : 1'b0;
    int ps, pe, posEff;
    @(negedge clk);
    detectEn = det; edgeRising = pol; delaySel = 3'(dly);
    resetPos = 2'(pos); ratio2Mode = r2; clampReq = clampBit; syncIn = idle;
    repeat (22) @(negedge clk);
    syncIn = ~idle;
    if (det) begin ps = 2 + dly; pe = ps; end
    else     begin ps = 2; pe = 1 + width; end
    posEff = r2 ? 1 : pos;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); @(negedge clk);
      checkAll(i, ps, pe, posEff, clampBit, pulseTag, resetTag);
      if (det && i == 2) syncIn = idle;
      if (!det && i == width - 1) syncIn = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; syncIn = 1'b0; detectEn = 1'b0; edgeRising = 1'b1;
    delaySel = 3'd0; resetPos = 2'b01; ratio2Mode = 1'b0; clampReq = 1'b1;
    repeat (3) @(negedge clk);
    // R9: outputs low in reset
    check("R9", "syncPulse", syncPulse, 1'b0);
    check("R9", "videoStrobe", videoStrobe, 1'b0);
    check("R9", "resetStrobe", resetStrobe, 1'b0);
    check("R9", "clampStrobe", clampStrobe, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R9", "syncPulse idle", syncPulse, 1'b0);
      check("R9", "resetStrobe idle", resetStrobe, 1'b0);
    end

    // R2 R3 R6 R7: full detect-mode sweep
    for (int pol = 0; pol < 2; pol++)
      for (int d = 0; d < 8; d++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++)
            runCase(1'b1, 1'(pol), d, p, 1'b0, 1'(c), 1, pol ? "R3" : "R2", "R6");

    // R1: pass-through, widths 1..3, polarity and delay settings ignored
    for (int w = 1; w < 4; w++)
      for (int d = 0; d < 8; d += 3)
        runCase(1'b0, 1'(d & 1), d, w - 1, 1'b0, 1'(w & 1), w, "R1", "R6");

    // R8: half-ratio mode forces the normal reset position
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 2; c++)
        runCase(1'b1, 1'b1, 2, p, 1'b1, 1'(c), 1, "R3", "R8");

    // R4: second rising edge while a delay of 5 is pending
    @(negedge clk);
    detectEn = 1'b1; edgeRising = 1'b1; delaySel = 3'd5; resetPos = 2'b01;
    ratio2Mode = 1'b0; clampReq = 1'b1; syncIn = 1'b0;
    repeat (22) @(negedge clk);
    syncIn = 1'b1;
    for (int i = 0; i < 22; i++) begin
      @(posedge clk); @(negedge clk);
      checkAll(i, 9, 9, 1, 1'b1, "R4", "R6");
      if (i == 0) syncIn = 1'b0;
      if (i == 1) syncIn = 1'b1;
      if (i == 4) syncIn = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule